// File: doc/BRIEF.md
# Byte-Serial Peripheral Interface Controller

This block moves bytes over a four-signal synchronous serial link. It works as either the clocking side (master) or the clocked side (slave). Software uses a small register bus. It writes a byte into a one-deep transmit holding register and reads received bytes from a receive holding register. It watches a control/status byte whose event bits stay set until software writes them back to zero. An interrupt line reports any of these events while interrupts are enabled.

The select line can be wired in three ways. In three-wire operation the select pin is ignored. In four-wire shared-bus operation the select pin is an input. A slave answers only while it is low, and a master treats a low level as another master taking the bus. In four-wire single-master operation the block drives the select pin from a control bit. The master shifts data MSB first, with the clock idling low and data sampled on the rising edge. Each clock half-period lasts a fixed number of system cycles.

Top module: `spi_unit`

## Requirements
- R1: After reset, the control register (address 0) reads 0x06 and the config register (address 2) reads 0x00. The irq output and all output enables are 0. Control bits from MSB to LSB are: done, collision, fault, overrun, select mode[1:0], tx-empty, enable. Config bit 0 is master and bit 1 is interrupt enable.
- R2: The tx-empty bit (control bit 1) is read-only. A write to the data register (address 1) clears it. It returns to 1 when the held byte moves into the shift register.
- R3: A data-register write while tx-empty is 0 is discarded. The held byte is kept and the collision bit (bit 6) is set.
- R4: In master mode with enable set, a held byte starts a transfer when the shifter is idle. MOSI carries the byte MSB first, and SCK idles low. Each SCK level lasts HALF_DIV cycles, and MISO is captured on SCK rising. At the end the received byte is readable at address 1 and the done bit (bit 7) is set.
- R5: Event bits never clear by hardware. A control-register write of 0 to a bit clears it.
- R6: In master mode with select mode 01, a low select input sets the fault bit (bit 5). It also clears the master bit and releases SCK and MOSI (output enables 0).
- R7: In slave mode the block shifts MOSI in on each SCK rising edge while selected. It presents the held byte MSB first on MISO. After 8 bits the byte is readable at address 1 and the done bit is set.
- R8: In slave mode, when a byte completes while the previous received byte is still unread (no data-register read since), the overrun bit (bit 4) is set. Address 1 keeps the earlier byte.
- R9: In slave mode 01, select going high drops a partial byte without setting any bit and releases MISO. The next full byte is received correctly.
- R10: Select mode 00 ignores the select pin, and a slave is always selected. Mode 1x drives the select pin (nss_oe=1) with value equal to mode bit 0 and never raises a fault.
- R11: With enable 0, no transfer runs and all serial output enables are 0. The receive register is not updated, but register writes are still taken.
- R12: irq is 1 exactly when interrupt enable is set and at least one of done, collision, fault or overrun is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (consumes received byte at address 1) |
| bus_addr | input | 2 | Register address: 0 control, 1 data, 2 config |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock drive enable |
| sck_i | input | 1 | Serial clock in (slave) |
| mosi_o | output | 1 | Master data out |
| mosi_oe | output | 1 | Master data drive enable |
| mosi_i | input | 1 | Master data in (slave) |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Slave data drive enable |
| miso_i | input | 1 | Slave data in (master) |
| nss_o | output | 1 | Select pin value when driven |
| nss_oe | output | 1 | Select pin drive enable |
| nss_i | input | 1 | Select pin input |

## Verification
A register write shows on the read port one cycle after the write edge, and reads are combinational within the cycle. The bench therefore samples one half-cycle after the strobe. A master transfer starts one cycle after a byte is held, and SCK then toggles every HALF_DIV cycles. The bench follows SCK and samples MOSI as soon as it sees SCK high. It also counts the high phase of the first bit against HALF_DIV. Slave inputs pass two synchronizer stages and one edge register, so a slave event is due three cycles after the SCK edge. The bench holds each SCK level for six cycles and reads the flags only after that.

// File: rtl/spi_unit_pkg.sv
package spi_unit_pkg;
    localparam int unsigned DW = 8;
    localparam int unsigned CW = $clog2(DW);

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_DATA = 2'd1,
        ADDR_CFG  = 2'd2
    } reg_addr_e;

    typedef enum logic [1:0] {
        SEL_3WIRE   = 2'b00,
        SEL_SHARED  = 2'b01,
        SEL_DRIVE_0 = 2'b10,
        SEL_DRIVE_1 = 2'b11
    } sel_mode_e;

    typedef struct packed {
        logic          done;
        logic          wcol;
        logic          fault;
        logic          ovr;
        logic [1:0]    mode;
        logic          txe;
        logic          en;
        logic          master;
        logic          ie;
        logic [DW-1:0] txbuf;
        logic [DW-1:0] rxbuf;
        logic          rx_full;
        logic [DW-1:0] shreg;
        logic [CW-1:0] cnt;
        logic          busy;
        logic          sck;
        logic          samp;
        logic          sl_loaded;
        logic          sck_prev;
    } state_t;
endpackage

// File: rtl/spi_unit_sync.sv
module spi_unit_sync #(
    parameter int unsigned    W       = 1,
    parameter int unsigned    STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/spi_unit_tick.sv
module spi_unit_tick #(
    parameter int unsigned HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned TW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [TW-1:0] TOP = TW'(HALF - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == TOP);
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_unit.sv
module spi_unit
    import spi_unit_pkg::*;
#(
    parameter int unsigned HALF_DIV = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq,
    output logic          sck_o,
    output logic          sck_oe,
    input  logic          sck_i,
    output logic          mosi_o,
    output logic          mosi_oe,
    input  logic          mosi_i,
    output logic          miso_o,
    output logic          miso_oe,
    input  logic          miso_i,
    output logic          nss_o,
    output logic          nss_oe,
    input  logic          nss_i
);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    state_t q, d;
    logic   ctrl_wr, data_wr, cfg_wr, data_rd;
    logic   sck_s, mosi_s, nss_s, sl_sel, sck_rise, tick;

    spi_unit_sync #(.W(3), .STAGES(2), .RST_VAL(3'b001)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sck_i, mosi_i, nss_i}),
        .dout ({sck_s, mosi_s, nss_s})
    );

    spi_unit_tick #(.HALF(HALF_DIV)) i_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (q.en && q.master && q.busy),
        .tick (tick)
    );

    always_comb begin
        d        = q;
        ctrl_wr  = bus_wr && (bus_addr == ADDR_CTRL);
        data_wr  = bus_wr && (bus_addr == ADDR_DATA);
        cfg_wr   = bus_wr && (bus_addr == ADDR_CFG);
        data_rd  = bus_rd && (bus_addr == ADDR_DATA);
        sl_sel   = (q.mode != SEL_SHARED) || !nss_s;
        sck_rise = sck_s && !q.sck_prev;
        d.sck_prev = sck_s;

        // register bus side
        if (ctrl_wr) begin
            d.done  = bus_wdata[7];
            d.wcol  = bus_wdata[6];
            d.fault = bus_wdata[5];
            d.ovr   = bus_wdata[4];
            d.mode  = bus_wdata[3:2];
            d.en    = bus_wdata[0];
        end
        if (cfg_wr) begin
            d.master = bus_wdata[0];
            d.ie     = bus_wdata[1];
        end
        if (data_rd) d.rx_full = 1'b0;
        if (data_wr) begin
            if (q.txe) begin
                d.txbuf = bus_wdata;
                d.txe   = 1'b0;
            end else begin
                d.wcol = 1'b1;
            end
        end

        // serial engine
        if (!q.en) begin
            d.busy      = 1'b0;
            d.cnt       = '0;
            d.sck       = 1'b0;
            d.sl_loaded = 1'b0;
        end else if (q.master) begin
            d.sl_loaded = 1'b0;
            if (q.mode == SEL_SHARED && !nss_s) begin
                d.fault  = 1'b1;
                d.master = 1'b0;
                d.busy   = 1'b0;
                d.cnt    = '0;
                d.sck    = 1'b0;
            end else if (!q.busy) begin
                if (!q.txe) begin
                    d.shreg = q.txbuf;
                    d.txe   = 1'b1;
                    d.busy  = 1'b1;
                    d.cnt   = '0;
                    d.sck   = 1'b0;
                end
            end else if (tick) begin
                if (!q.sck) begin
                    d.sck  = 1'b1;
                    d.samp = miso_i;
                end else begin
                    d.sck   = 1'b0;
                    d.shreg = {q.shreg[DW-2:0], q.samp};
                    d.cnt   = q.cnt + 1'b1;
                    if (q.cnt == LAST) begin
                        d.busy    = 1'b0;
                        d.cnt     = '0;
                        d.done    = 1'b1;
                        d.rxbuf   = {q.shreg[DW-2:0], q.samp};
                        d.rx_full = 1'b1;
                    end
                end
            end
        end else begin
            d.busy = 1'b0;
            d.sck  = 1'b0;
            if (!sl_sel) begin
                d.cnt       = '0;
                d.sl_loaded = 1'b0;
            end else if (sck_rise) begin
                d.shreg = {q.shreg[DW-2:0], mosi_s};
                d.cnt   = q.cnt + 1'b1;
                if (q.cnt == LAST) begin
                    d.cnt       = '0;
                    d.sl_loaded = 1'b0;
                    d.done      = 1'b1;
                    if (q.rx_full && !data_rd) begin
                        d.ovr = 1'b1;
                    end else begin
                        d.rxbuf   = {q.shreg[DW-2:0], mosi_s};
                        d.rx_full = 1'b1;
                    end
                end
            end else if (!q.sl_loaded && q.cnt == '0 && !q.txe) begin
                d.shreg     = q.txbuf;
                d.txe       = 1'b1;
                d.sl_loaded = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.mode <= SEL_SHARED;
            q.txe  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_CTRL: bus_rdata = {q.done, q.wcol, q.fault, q.ovr, q.mode, q.txe, q.en};
            ADDR_DATA: bus_rdata = q.rxbuf;
            ADDR_CFG:  bus_rdata = {{(DW-2){1'b0}}, q.ie, q.master};
            default:   bus_rdata = '0;
        endcase
    end

    assign irq     = q.ie && (q.done || q.wcol || q.fault || q.ovr);
    assign sck_o   = q.sck;
    assign sck_oe  = q.en && q.master;
    assign mosi_o  = q.shreg[DW-1];
    assign mosi_oe = q.en && q.master;
    assign miso_o  = q.shreg[DW-1];
    assign miso_oe = q.en && !q.master && sl_sel;
    assign nss_o   = q.mode[0];
    assign nss_oe  = q.en && q.mode[1];
endmodule

// File: rtl/spi_unit_chk.sv
module spi_unit_chk
    import spi_unit_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   ctrl_wr,
    input logic   data_wr,
    input state_t st,
    input logic   irq,
    input logic   sck_oe,
    input logic   mosi_oe,
    input logic   miso_oe,
    input logic   nss_oe
);
    // R5
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st.done && !ctrl_wr |=> st.done);

    // R3
    wcol_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr && !st.txe |=> st.wcol && (st.txbuf == $past(st.txbuf)));

    // R2
    txe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr && st.txe |=> !st.txe);

    // R6
    fault_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st.fault) && !$past(ctrl_wr) |-> !st.master && !sck_oe && !mosi_oe);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st.en |-> !sck_oe && !mosi_oe && !miso_oe && !nss_oe);

    // R7
    one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(miso_oe && mosi_oe));

    // R12
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> st.ie);
endmodule

bind spi_unit spi_unit_chk i_spi_unit_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctrl_wr(ctrl_wr),
    .data_wr(data_wr),
    .st     (q),
    .irq    (irq),
    .sck_oe (sck_oe),
    .mosi_oe(mosi_oe),
    .miso_oe(miso_oe),
    .nss_oe (nss_oe)
);

// File: tb/test_spi_unit.sv
`timescale 1ns/1ps
module test_spi_unit;
    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, nss_o, nss_oe;
    logic       sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, nss_i = 1'b1;
    int         checks = 0, errors = 0;

    always #5 clk = ~clk;

    spi_unit #(.HALF_DIV(HALF)) i_spi_unit (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i),
        .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
        .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i),
        .nss_o(nss_o), .nss_oe(nss_oe), .nss_i(nss_i)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ctrl_val(input logic dn, input logic wc, input logic ft,
                                            input logic ov, input logic [1:0] md,
                                            input logic te, input logic en);
        return {dn, wc, ft, ov, md, te, en};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_sck(input logic lvl);
        for (int g = 0; g < 2000 && sck_o !== lvl; g++) @(negedge clk);
    endtask

    task automatic master_xfer(input logic [1:0] a, input logic [7:0] v, input logic [7:0] sb,
                               output logic [7:0] got, output int hi);
        miso_i = sb[7];
        got = 8'd0;
        hi = 0;
        wr(a, v);
        for (int i = 7; i >= 0; i--) begin
            wait_sck(1'b1);
            got[i] = mosi_o;
            if (i == 7) begin
                while (sck_o === 1'b1 && hi < 100) begin @(negedge clk); hi++; end
            end else begin
                wait_sck(1'b0);
            end
            if (i > 0) miso_i = sb[i-1];
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic slave_bits(input logic [7:0] mb, input int nbits, output logic [7:0] got);
        got = 8'd0;
        for (int i = 0; i < nbits; i++) begin
            mosi_i = mb[7-i];
            repeat (6) @(negedge clk);
            got[7-i] = miso_o;
            sck_i = 1'b1;
            repeat (6) @(negedge clk);
            sck_i = 1'b0;
        end
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v, got, tx, sb, last_rx;
        int hi;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl", v, 8'h06);
        rd(2'd2, v); chk("R1 cfg", v, 8'h00);
        chk("R1 irq", irq, 0);
        chk("R1 oe", {sck_oe, mosi_oe, miso_oe, nss_oe}, 0);

        // R11 disabled: writes taken, nothing moves
        wr(2'd2, 8'h01);
        wr(2'd0, 8'h04);
        wr(2'd1, 8'hA5);
        rd(2'd0, v); chk("R2 tx-empty cleared", v, ctrl_val(0,0,0,0,2'b01,0,0));
        repeat (40) @(negedge clk);
        chk("R11 sck released", sck_oe, 0);
        rd(2'd0, v); chk("R11 no transfer", v, ctrl_val(0,0,0,0,2'b01,0,0));

        // R3 collision
        wr(2'd1, 8'h3C);
        rd(2'd0, v); chk("R3 collision flag", v, ctrl_val(0,1,0,0,2'b01,0,0));

        // R4 / R3 enable, held byte goes out unchanged
        master_xfer(2'd0, 8'h05, 8'h5A, got, hi);
        chk("R3 buffer kept", got, 8'hA5);
        chk("R4 half period", hi, HALF);
        chk("R4 sck idle low", sck_o, 0);
        rd(2'd0, v); chk("R2 R4 done and tx-empty", v, ctrl_val(1,0,0,0,2'b01,1,1));
        rd(2'd1, v); chk("R4 received", v, 8'h5A);

        // R5 sticky
        repeat (20) @(negedge clk);
        rd(2'd0, v); chk("R5 still set", v[7], 1);
        chk("R12 irq masked", irq, 0);
        wr(2'd0, 8'h05);
        rd(2'd0, v); chk("R5 cleared", v, ctrl_val(0,0,0,0,2'b01,1,1));

        // R12 interrupt
        wr(2'd2, 8'h03);
        master_xfer(2'd1, 8'h81, 8'h18, got, hi);
        chk("R12 irq raised", irq, 1);
        wr(2'd0, 8'h05);
        chk("R12 irq dropped", irq, 0);

        // R4 random master transfers
        for (int k = 0; k < 6; k++) begin
            tx = 8'($urandom);
            sb = 8'($urandom);
            master_xfer(2'd1, tx, sb, got, hi);
            chk("R4 random mosi", got, tx);
            rd(2'd1, v); chk("R4 random miso", v, sb);
            wr(2'd0, 8'h05);
        end

        // R6 mode fault
        nss_i = 1'b0;
        repeat (6) @(negedge clk);
        rd(2'd0, v); chk("R6 fault flag", v, ctrl_val(0,0,1,0,2'b01,1,1));
        rd(2'd2, v); chk("R6 master cleared", v, 8'h02);
        chk("R6 lines released", {sck_oe, mosi_oe}, 0);
        chk("R12 irq on fault", irq, 1);
        nss_i = 1'b1;
        wr(2'd0, 8'h05);

        // R10 driven select
        wr(2'd2, 8'h01);
        wr(2'd0, 8'h09);
        nss_i = 1'b0;
        repeat (6) @(negedge clk);
        rd(2'd0, v); chk("R10 no fault in mode 10", v, ctrl_val(0,0,0,0,2'b10,1,1));
        chk("R10 nss driven low", {nss_oe, nss_o}, 2'b10);
        wr(2'd0, 8'h0D);
        chk("R10 nss driven high", {nss_oe, nss_o}, 2'b11);
        nss_i = 1'b1;

        // R7 slave transfer
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h05);
        nss_i = 1'b0;
        wr(2'd1, 8'hC3);
        slave_bits(8'h96, 8, got);
        chk("R7 miso byte", got, 8'hC3);
        rd(2'd1, v); chk("R7 received", v, 8'h96);
        rd(2'd0, v); chk("R7 done", v, ctrl_val(1,0,0,0,2'b01,1,1));
        wr(2'd0, 8'h05);

        // R8 overrun
        slave_bits(8'h11, 8, got);
        slave_bits(8'h22, 8, got);
        rd(2'd0, v); chk("R8 overrun flag", v, ctrl_val(1,0,0,1,2'b01,1,1));
        rd(2'd1, v); chk("R8 old byte kept", v, 8'h11);
        wr(2'd0, 8'h05);

        // R9 abort on deselect
        slave_bits(8'hFF, 3, got);
        nss_i = 1'b1;
        repeat (6) @(negedge clk);
        chk("R9 miso released", miso_oe, 0);
        rd(2'd0, v); chk("R9 no flag", v, ctrl_val(0,0,0,0,2'b01,1,1));
        nss_i = 1'b0;
        repeat (4) @(negedge clk);
        slave_bits(8'h4B, 8, got);
        rd(2'd1, v); chk("R9 next byte", v, 8'h4B);
        wr(2'd0, 8'h05);

        // R10 three-wire slave ignores select
        wr(2'd0, 8'h01);
        nss_i = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 3-wire selected", miso_oe, 1);
        slave_bits(8'h7E, 8, got);
        rd(2'd1, v); chk("R10 3-wire received", v, 8'h7E);

        // R7 random slave transfers
        wr(2'd0, 8'h05);
        nss_i = 1'b0;
        last_rx = 8'h00;
        for (int k = 0; k < 6; k++) begin
            tx = 8'($urandom);
            sb = 8'($urandom);
            wr(2'd1, tx);
            slave_bits(sb, 8, got);
            chk("R7 random miso", got, tx);
            rd(2'd1, v); chk("R7 random mosi", v, sb);
            last_rx = sb;
            wr(2'd0, 8'h05);
        end

        // R11 disabled slave keeps receive register
        wr(2'd0, 8'h04);
        slave_bits(8'hEE, 8, got);
        rd(2'd1, v); chk("R11 rx unchanged", v, last_rx);
        chk("R11 miso released", miso_oe, 0);
        rd(2'd0, v); chk("R11 no done", v[7], 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule